// File: doc/BRIEF.md
# Two-Level Translation Access Fault Evaluator

This unit decides whether one memory access may go ahead in a two-level page-table translation scheme. The requester presents the relevant control bits, the 32-bit domain access register, the type of the access (instruction fetch or data, byte or word, read or write, privileged or user), the virtual address, the first-level descriptor and, for page-mapped regions, the second-level entry. It raises `req_i` for one cycle. One cycle later the unit returns a completion flag, a fault flag, a 4-bit fault code and a pass flag.

The checks have a fixed priority. Alignment comes first, then first-level validity. After that, a section mapping is checked for its domain and then its access permission. A page mapping is checked for second-level validity, then its domain, then the access permission of the quarter-page the address falls in. The walk that fetches the descriptors, any caching of translations and the recording of fault addresses belong to the surrounding logic.

Top module: `mmu_fault_check`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next outputs are `done_o`=0, `fault_o`=0, `pass_o`=0 and `fault_code_o`=0000.
- R2: `done_o` is high in exactly the cycle after a cycle with `req_i` high. After a cycle without a request, `done_o`, `fault_o`, `pass_o` and `fault_code_o` are all zero.
- R3: When `align_chk_en_i` is 1, a data word access (`is_fetch_i`=0, `is_byte_i`=0) with `va_i[1:0]` not equal to 00 faults with code 0001. This holds whatever the value of `xlat_en_i`.
- R4: An instruction fetch or a byte access never gets code 0001. No access gets code 0001 while `align_chk_en_i` is 0.
- R5: When an alignment fault occurs, code 0001 is reported and every other check is ignored.
- R6: When `xlat_en_i` is 0, no translation, domain or permission fault is raised, so any access that is not misaligned passes.
- R7: The first-level type is `l1_desc_i[1:0]`: 10 means section and 01 means page table. The values 00 and 11 give a section translation fault, code 0101.
- R8: For a page table, the second-level type is `l2_desc_i[1:0]`: 01 means large page and 10 means small page. The values 00 and 11 give a page translation fault, code 0111. This code is reported even when the domain check would also fail.
- R9: `l1_desc_i[8:5]` holds an index i that selects the domain value `dacr_i[2i+1:2i]`. A domain value of 00 or 10 faults, with code 1001 for a section and code 1011 for a page.
- R10: A domain value of 11 passes without any permission check.
- R11: A domain value of 01 applies the section permission bits `l1_desc_i[11:10]`, read together with `sys_prot_i`. AP 00 with `sys_prot_i`=0 denies every access. AP 00 with `sys_prot_i`=1 allows only privileged reads. AP 01 allows only privileged accesses. AP 10 allows user reads and privileged reads and writes. AP 11 allows every access. A denied access gets code 1101.
- R12: For a client page, the AP field is taken from `l2_desc_i`: quarter 0 uses [5:4], quarter 1 uses [7:6], quarter 2 uses [9:8] and quarter 3 uses [11:10]. The quarter index is `va_i[11:10]` for a small page and `va_i[15:14]` for a large page. The field is decoded as in R11, and a denied access gets code 1111.
- R13: `pass_o` is high exactly when `done_o` is high and `fault_o` is low. `fault_o` is high exactly when `done_o` is high and the code is not 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | One-cycle request to evaluate the presented access |
| xlat_en_i | input | 1 | Translation enable |
| align_chk_en_i | input | 1 | Alignment checking enable |
| sys_prot_i | input | 1 | Modifies how AP 00 is read |
| dacr_i | input | 32 | Sixteen 2-bit domain values |
| is_fetch_i | input | 1 | Access is an instruction fetch |
| is_byte_i | input | 1 | Access is a byte access |
| is_write_i | input | 1 | Access is a write |
| is_priv_i | input | 1 | Access is privileged |
| va_i | input | 32 | Virtual address |
| l1_desc_i | input | 32 | First-level descriptor |
| l2_desc_i | input | 32 | Second-level entry |
| done_o | output | 1 | Result valid, one cycle after the request |
| fault_o | output | 1 | The access faulted |
| pass_o | output | 1 | The access is allowed |
| fault_code_o | output | 4 | Fault type, 0000 when there is no fault |

## Verification
The hardest case to reach is a sub-page permission fault that depends on the quarter index. To reach it, the first-level type must be page table, the second-level entry must be valid, the selected domain must be client, and the quarter picked by the address bits must hold an AP value that refuses this particular privilege and direction. The address must also be word aligned, or alignment checking must be off. Directed stimulus builds second-level entries whose four AP fields all differ. It then moves a user write across the quarters, first with the small-page index bits and then with the large-page index bits. A long stretch of random stimulus follows. It sets the descriptor type bits and the domain values independently and keeps the address aligned half the time. Each cycle's result is compared with a behavioural model.

// File: rtl/mmu_fault_pkg.sv
// Package: shared encodings for the access fault evaluator.
// Assumes: descriptor type and domain encodings are fixed by the table format.
package mmu_fault_pkg;

    typedef enum logic [3:0] {
        FC_NONE     = 4'b0000,
        FC_ALIGN    = 4'b0001,
        FC_SEC_XLT  = 4'b0101,
        FC_PG_XLT   = 4'b0111,
        FC_SEC_DOM  = 4'b1001,
        FC_PG_DOM   = 4'b1011,
        FC_SEC_PERM = 4'b1101,
        FC_SUB_PERM = 4'b1111
    } fault_code_e;

    typedef enum logic [1:0] {
        DOM_NOACC   = 2'b00,
        DOM_CLIENT  = 2'b01,
        DOM_RSVD    = 2'b10,
        DOM_MANAGER = 2'b11
    } dom_kind_e;

    localparam logic [1:0] L1_PAGE_TBL = 2'b01;
    localparam logic [1:0] L1_SECTION  = 2'b10;
    localparam logic [1:0] L2_LARGE    = 2'b01;
    localparam logic [1:0] L2_SMALL    = 2'b10;

endpackage

// File: rtl/mmu_align_chk.sv
// Module: flags a misaligned data word access.
// Assumes: only the two lowest address bits matter; fetches and bytes are exempt.
module mmu_align_chk (
    input  logic       chk_en_i,
    input  logic       is_fetch_i,
    input  logic       is_byte_i,
    input  logic [1:0] va_lo_i,
    output logic       misalign_o
);

    // A data word access with either low address bit set is misaligned.
    always_comb begin
        misalign_o = chk_en_i && !is_fetch_i && !is_byte_i && (va_lo_i != 2'b00);
    end

    // R4: fetches and byte accesses never report misalignment.
    always_comb begin
        if (is_fetch_i || is_byte_i) begin
            a_r4_exempt_kinds : assert (!misalign_o);
        end
    end

endmodule

// File: rtl/mmu_domain_sel.sv
// Module: picks one 2-bit domain value out of the packed domain register.
// Assumes: N_DOM is a power of two so every index value names a field.
module mmu_domain_sel #(
    parameter int N_DOM = 16,
    localparam int DOM_W = $clog2(N_DOM)
) (
    input  logic [2*N_DOM-1:0] dacr_i,
    input  logic [DOM_W-1:0]   idx_i,
    output logic [1:0]         dom_o
);

    logic [1:0] fields [N_DOM];

    // Split the register into one field per domain.
    for (genvar g = 0; g < N_DOM; g++) begin : g_field
        assign fields[g] = dacr_i[2*g+1:2*g];
    end

    // Select the field named by the descriptor.
    always_comb begin
        dom_o = fields[idx_i];
    end

endmodule

// File: rtl/mmu_ap_select.sv
// Module: chooses the quarter-page AP field of a second-level entry.
// Assumes: four consecutive 2-bit AP fields start at AP_LSB; quarter bits at
//          SMALL_QTR_LSB for small pages and LARGE_QTR_LSB for large pages.
module mmu_ap_select #(
    parameter int DESC_W        = 32,
    parameter int VA_W          = 32,
    parameter int AP_LSB        = 4,
    parameter int N_QTR         = 4,
    parameter int SMALL_QTR_LSB = 10,
    parameter int LARGE_QTR_LSB = 14,
    localparam int QTR_W = $clog2(N_QTR)
) (
    input  logic [DESC_W-1:0] l2_i,
    input  logic [VA_W-1:0]   va_i,
    input  logic              large_i,
    output logic [1:0]        ap_o
);

    logic [1:0]       ap_fld [N_QTR];
    logic [QTR_W-1:0] qtr;
    logic             unused_va;

    // Unpack the quarter AP fields, lowest quarter first.
    for (genvar g = 0; g < N_QTR; g++) begin : g_ap
        assign ap_fld[g] = l2_i[AP_LSB+2*g +: 2];
    end

    // The quarter index comes from address bits that depend on page size.
    always_comb begin
        qtr  = large_i ? va_i[LARGE_QTR_LSB +: QTR_W] : va_i[SMALL_QTR_LSB +: QTR_W];
        ap_o = ap_fld[qtr];
    end

    assign unused_va = ^{va_i, l2_i};

endmodule

// File: rtl/mmu_perm_chk.sv
// Module: decides whether an AP code allows the access in a client domain.
// Assumes: the modifier bit changes only the meaning of AP 00.
module mmu_perm_chk (
    input  logic [1:0] ap_i,
    input  logic       sys_prot_i,
    input  logic       priv_i,
    input  logic       write_i,
    output logic       allow_o
);

    // Decode the AP code against privilege and direction.
    always_comb begin
        unique case (ap_i)
            2'b00:   allow_o = sys_prot_i && priv_i && !write_i;
            2'b01:   allow_o = priv_i;
            2'b10:   allow_o = priv_i || !write_i;
            default: allow_o = 1'b1;
        endcase
    end

    // R11: only the fully open code admits a user write.
    always_comb begin
        if (!priv_i && write_i && ap_i != 2'b11) begin
            a_r11_user_write_needs_open : assert (!allow_o);
        end
    end

endmodule

// File: rtl/mmu_fault_check.sv
// Module: top of the access fault evaluator. Applies the alignment,
//         translation, domain and permission checks in priority order and
//         registers the outcome one cycle after req_i.
// Assumes: the descriptors on the inputs belong to va_i in the request cycle;
//          synchronous active-low reset.
module mmu_fault_check #(
    parameter int VA_W    = 32,
    parameter int DESC_W  = 32,
    parameter int N_DOM   = 16,
    parameter int DOM_LSB = 5,
    parameter int SAP_LSB = 10,
    localparam int DOM_W  = $clog2(N_DOM),
    localparam int DACR_W = 2 * N_DOM
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              xlat_en_i,
    input  logic              align_chk_en_i,
    input  logic              sys_prot_i,
    input  logic [DACR_W-1:0] dacr_i,
    input  logic              is_fetch_i,
    input  logic              is_byte_i,
    input  logic              is_write_i,
    input  logic              is_priv_i,
    input  logic [VA_W-1:0]   va_i,
    input  logic [DESC_W-1:0] l1_desc_i,
    input  logic [DESC_W-1:0] l2_desc_i,
    output logic              done_o,
    output logic              fault_o,
    output logic              pass_o,
    output logic [3:0]        fault_code_o
);
    import mmu_fault_pkg::*;

    logic        misalign;
    logic        l1_ok, is_section, l2_ok, is_large;
    logic [1:0]  dom_val, sec_ap, pg_ap, ap_used;
    logic        dom_bad, dom_client, perm_ok;
    fault_code_e code_nxt;
    logic        unused_bits;

    mmu_align_chk i_align (
        .chk_en_i   (align_chk_en_i),
        .is_fetch_i (is_fetch_i),
        .is_byte_i  (is_byte_i),
        .va_lo_i    (va_i[1:0]),
        .misalign_o (misalign)
    );

    mmu_domain_sel #(.N_DOM(N_DOM)) i_dom (
        .dacr_i (dacr_i),
        .idx_i  (l1_desc_i[DOM_LSB +: DOM_W]),
        .dom_o  (dom_val)
    );

    mmu_ap_select #(.DESC_W(DESC_W), .VA_W(VA_W)) i_apsel (
        .l2_i    (l2_desc_i),
        .va_i    (va_i),
        .large_i (is_large),
        .ap_o    (pg_ap)
    );

    mmu_perm_chk i_perm (
        .ap_i       (ap_used),
        .sys_prot_i (sys_prot_i),
        .priv_i     (is_priv_i),
        .write_i    (is_write_i),
        .allow_o    (perm_ok)
    );

    // Classify both descriptors and the selected domain.
    always_comb begin
        l1_ok      = (l1_desc_i[1:0] == L1_SECTION) || (l1_desc_i[1:0] == L1_PAGE_TBL);
        is_section = (l1_desc_i[1:0] == L1_SECTION);
        l2_ok      = (l2_desc_i[1:0] == L2_LARGE) || (l2_desc_i[1:0] == L2_SMALL);
        is_large   = (l2_desc_i[1:0] == L2_LARGE);
        dom_bad    = (dom_val == DOM_NOACC) || (dom_val == DOM_RSVD);
        dom_client = (dom_val == DOM_CLIENT);
        sec_ap     = l1_desc_i[SAP_LSB +: 2];
        ap_used    = is_section ? sec_ap : pg_ap;
    end

    // Apply the checks in fixed priority and name the first one that fails.
    always_comb begin
        code_nxt = FC_NONE;
        if (misalign) begin
            code_nxt = FC_ALIGN;
        end else if (xlat_en_i) begin
            if (!l1_ok) begin
                code_nxt = FC_SEC_XLT;
            end else if (is_section) begin
                if (dom_bad)                      code_nxt = FC_SEC_DOM;
                else if (dom_client && !perm_ok)  code_nxt = FC_SEC_PERM;
            end else begin
                if (!l2_ok)                       code_nxt = FC_PG_XLT;
                else if (dom_bad)                 code_nxt = FC_PG_DOM;
                else if (dom_client && !perm_ok)  code_nxt = FC_SUB_PERM;
            end
        end
    end

    // Register the verdict for the cycle after a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o       <= 1'b0;
            fault_o      <= 1'b0;
            pass_o       <= 1'b0;
            fault_code_o <= FC_NONE;
        end else begin
            done_o       <= req_i;
            fault_o      <= req_i && (code_nxt != FC_NONE);
            pass_o       <= req_i && (code_nxt == FC_NONE);
            fault_code_o <= req_i ? code_nxt : FC_NONE;
        end
    end

    assign unused_bits = ^{va_i, l1_desc_i, l2_desc_i};

    // R2: a completion follows every request and only a request.
    a_r2_done_tracks_req : assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (done_o == $past(req_i)));

    // R13: pass and fault are exclusive and both need a completion.
    a_r13_pass_fault_excl : assert property (@(posedge clk) disable iff (!rst_n)
        (pass_o || fault_o) |-> (done_o && (pass_o != fault_o)));

    // R13: a fault flag always comes with a non-zero code.
    a_r13_fault_has_code : assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (fault_code_o != 4'b0000));

    // R3: a misaligned data word request yields the alignment code.
    a_r3_align_code : assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && req_i && align_chk_en_i && !is_fetch_i && !is_byte_i
              && (va_i[1:0] != 2'b00)) |-> (fault_code_o == FC_ALIGN));

    // R6: with translation and alignment checking both off, every request passes.
    a_r6_xlat_off_pass : assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && req_i && !xlat_en_i && !align_chk_en_i) |-> pass_o);

    // R8: an invalid second-level entry wins over any domain outcome.
    a_r8_pg_xlt_first : assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && req_i && xlat_en_i && !misalign
              && (l1_desc_i[1:0] == L1_PAGE_TBL)
              && ((l2_desc_i[1:0] == 2'b00) || (l2_desc_i[1:0] == 2'b11)))
        |-> (fault_code_o == FC_PG_XLT));

endmodule

// File: tb/test_mmu_fault_check.sv
module test_mmu_fault_check;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        xen = 1'b0, aen = 1'b0, sprot = 1'b0;
    logic [31:0] dacr = '0;
    logic        fetch = 1'b0, byt = 1'b0, wr = 1'b0, priv = 1'b0;
    logic [31:0] va = '0, l1 = '0, l2 = '0;
    logic        done, fault, pass;
    logic [3:0]  code;

    int n_chk = 0;
    int n_bad = 0;
    int exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mmu_fault_check i_mmu_fault_check (
        .clk(clk), .rst_n(rst_n), .req_i(req), .xlat_en_i(xen),
        .align_chk_en_i(aen), .sys_prot_i(sprot), .dacr_i(dacr),
        .is_fetch_i(fetch), .is_byte_i(byt), .is_write_i(wr), .is_priv_i(priv),
        .va_i(va), .l1_desc_i(l1), .l2_desc_i(l2),
        .done_o(done), .fault_o(fault), .pass_o(pass), .fault_code_o(code)
    );

    // Behavioural AP decode, written as a table of allowed combinations.
    function automatic bit allowed(int ap, bit s, bit p, bit w);
        if (ap == 3) return 1;
        if (ap == 2) return p || !w;
        if (ap == 1) return p;
        return s && p && !w;
    endfunction

    // Behavioural model of the whole verdict; returns the expected code.
    function automatic int model();
        int t1, t2, dom, q, ap;
        if (aen && !fetch && !byt && (va % 4 != 0)) return 1;
        if (!xen) return 0;
        t1 = l1 & 3;
        if (t1 == 0 || t1 == 3) return 5;
        dom = (dacr >> (2 * ((l1 >> 5) & 15))) & 3;
        if (t1 == 2) begin
            if (dom == 0 || dom == 2) return 9;
            if (dom == 3) return 0;
            return allowed((l1 >> 10) & 3, sprot, priv, wr) ? 0 : 13;
        end
        t2 = l2 & 3;
        if (t2 == 0 || t2 == 3) return 7;
        if (dom == 0 || dom == 2) return 11;
        if (dom == 3) return 0;
        q  = (t2 == 1) ? ((va >> 14) & 3) : ((va >> 10) & 3);
        ap = (l2 >> (4 + 2 * q)) & 3;
        return allowed(ap, sprot, priv, wr) ? 0 : 15;
    endfunction

    function automatic string tag_of(int e);
        case (e)
            -1: return "R2";
            0:  return "R13";
            1:  return "R3";
            5:  return "R7";
            7:  return "R8";
            9, 11: return "R9";
            13: return "R11";
            default: return "R12";
        endcase
    endfunction

    // Queue the expectation for the current inputs, then compare a cycle later.
    task automatic step(input string tag);
        int e, got_e;
        string t;
        exp_q.push_back(req ? model() : -1);
        tag_q.push_back(tag);
        @(negedge clk);
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (e < 0) begin
            if (done || fault || pass || code != 0) begin
                n_bad++;
                $display("FAIL %s idle: done=%0b fault=%0b pass=%0b code=%0d expected all zero",
                         t, done, fault, pass, code);
            end
        end else begin
            got_e = int'(code);
            if (!done || got_e != e || fault != (e != 0) || pass != (e == 0)) begin
                n_bad++;
                $display("FAIL %s: done=%0b fault=%0b pass=%0b code=%0d expected code=%0d",
                         t, done, fault, pass, got_e, e);
            end
        end
    endtask

    function automatic logic [31:0] l1_sec(int dom, int ap);
        return 32'((ap << 10) | (dom << 5) | 2);
    endfunction
    function automatic logic [31:0] l1_tbl(int dom);
        return 32'((dom << 5) | 1);
    endfunction
    function automatic logic [31:0] l2_ent(int typ, int a3, int a2, int a1, int a0);
        return 32'((a3 << 10) | (a2 << 8) | (a1 << 6) | (a0 << 4) | typ);
    endfunction

    task automatic acc(input bit f, input bit b, input bit w, input bit p, input logic [31:0] a);
        fetch = f; byt = b; wr = w; priv = p; va = a; req = 1'b1;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: outputs cleared by reset
        n_chk++;
        if (done || fault || pass || code != 0) begin
            n_bad++;
            $display("FAIL R1 reset: done=%0b fault=%0b pass=%0b code=%0d expected 0",
                     done, fault, pass, code);
        end
        rst_n = 1'b1;
        step("R2");                       // idle cycle, R2

        // R3 alignment, translation off
        aen = 1; xen = 0; acc(0, 0, 0, 1, 32'h1001); step("R3");
        acc(0, 0, 1, 0, 32'h1002); step("R3");
        // R5 alignment beats invalid L1
        xen = 1; l1 = 32'h0; acc(0, 0, 0, 1, 32'h3); step("R5");
        // R4 exemptions
        xen = 0; acc(1, 0, 0, 1, 32'h2); step("R4");
        acc(0, 1, 1, 0, 32'h3); step("R4");
        aen = 0; acc(0, 0, 0, 0, 32'h1); step("R4");
        // R6 translation off ignores a bad descriptor
        xen = 0; l1 = 32'h3; acc(0, 0, 1, 0, 32'h0); step("R6");
        // R7 invalid L1 codes
        xen = 1; l1 = 32'h0; step("R7");
        l1 = 32'hFFFF_FFFF; step("R7");
        // R8 invalid L2 with a no-access domain
        dacr = 32'h0; l1 = l1_tbl(4); l2 = 32'h0; step("R8");
        l2 = 32'h3; step("R8");
        // R9 domain faults, including the top domain index
        dacr = 32'h8000_0000; l1 = l1_sec(15, 3); step("R9");
        dacr = 32'h0000_0200; l1 = l1_tbl(4); l2 = l2_ent(2, 3, 3, 3, 3); step("R9");
        // R10 manager ignores a closed AP
        dacr = 32'hC000_0000; l1 = l1_sec(15, 0); acc(0, 0, 1, 0, 32'h0); step("R10");
        // R11 client section decode
        dacr = 32'h0000_0004; sprot = 0; l1 = l1_sec(1, 0); acc(0, 0, 0, 1, 32'h0); step("R11");
        sprot = 1; step("R11");
        acc(0, 0, 1, 1, 32'h0); step("R11");
        l1 = l1_sec(1, 1); acc(0, 0, 0, 0, 32'h0); step("R11");
        l1 = l1_sec(1, 2); step("R11");
        acc(0, 0, 1, 0, 32'h0); step("R11");
        l1 = l1_sec(1, 3); step("R11");
        // R12 sub-page quarters: ap0=11 ap1=00 ap2=10 ap3=01, user write
        sprot = 0; l1 = l1_tbl(1);
        l2 = l2_ent(2, 1, 2, 0, 3); acc(0, 0, 1, 0, 32'h0000_0000); step("R12");
        acc(0, 0, 1, 0, 32'h0000_0400); step("R12");
        acc(0, 0, 0, 0, 32'h0000_0800); step("R12");
        acc(0, 0, 0, 0, 32'h0000_0C00); step("R12");
        l2 = l2_ent(1, 1, 2, 0, 3); acc(0, 0, 1, 0, 32'h0000_0C00); step("R12");
        acc(0, 0, 1, 0, 32'h0000_4000); step("R12");
        acc(0, 0, 0, 1, 32'h0000_C000); step("R12");
        req = 0; step("R2");

        // Random traffic, compared every cycle
        for (int i = 0; i < 3000; i++) begin
            req = $urandom_range(0, 3) != 0;
            xen = $urandom_range(0, 3) != 0;
            aen = 1'($urandom); sprot = 1'($urandom);
            dacr = $urandom; l1 = $urandom; l2 = $urandom;
            fetch = $urandom_range(0, 3) == 0; byt = $urandom_range(0, 3) == 0;
            wr = 1'($urandom); priv = 1'($urandom);
            va = $urandom;
            if ($urandom_range(0, 1) == 1) va[1:0] = 2'b00;
            step(tag_of(req ? model() : -1));
        end
        req = 0; step("R2");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule